// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous data store for a processor's secondary cache. Each word is 64 bits wide and split into eight byte lanes, and each lane has its own write enable. An access starts on a rising clock edge when either of two active-low address strobes is low. One strobe comes from the processor and the other from the cache controller. The start address is registered. Later beats of a four-beat burst are generated inside the block by a 2-bit counter, which steps only on edges where the active-low advance input is low. A strap input selects the beat order:

- XOR interleaved order.
- Linear wrap-around order.

Read data passes through the registered address and then an output register. The word therefore reaches the bus one clock after the edge that registers its address. An asynchronous active-low output enable gates the tri-state data bus, and `rdata_oe` reports whether the bus is driven. The chip select decides between a real access and a deselect. A deselect turns the bus off one clock after it is registered. The processor strobe is disregarded while chip select is inactive.

Top module: `pipe_burst_sram`

## Requirements
- R1: A new access starts at a rising edge when `stb_cpu_n` or `stb_ctl_n` is low (unless R7 applies) and `cs_n` is low. The access is a write if any bit of `lane_we_n` is low, and a read otherwise.
- R2: For a read registered at edge n, the addressed word is on `rdata` with `rdata_oe` high after edge n+1.
- R3: During a burst the beat counter moves only on edges where `adv_n` is low and no strobe is taken. On an edge with no strobe and `adv_n` high, `rdata` and `rdata_oe` keep their values.
- R4: Address bits [1:0] are the start offset S of a burst, and the upper bits stay fixed. With `ilv_order`=1, beat k reads offset S XOR k. With `ilv_order`=0, beat k reads offset (S+k) mod 4.
- R5: A write changes byte lane i (bits 8i+7..8i) only when `lane_we_n[i]` is 0. The other lanes keep their old contents.
- R6: A read of the same address on the cycle right after a partial write returns the merged word: new bytes in the written lanes and old bytes elsewhere.
- R7: An edge with `stb_cpu_n` low and `cs_n` high is ignored in full. There is no deselect, no advance and no write, and the outputs are unchanged.
- R8: An edge with `stb_ctl_n` low, `stb_cpu_n` high and `cs_n` high is a deselect. `rdata_oe` is 0 after the following edge, and later `adv_n` pulses do not restart output.
- R9: While `oe_n` is high, `rdata_oe` is 0 and `rdata` is high impedance, with no clock involved.
- R10: A taken strobe during a burst abandons that burst and loads a new start address with the count at zero.
- R11: After reset `rdata_oe` is 0 and no burst is active.
- R12: A write cycle leaves `rdata_oe` at 0 after the edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stb_cpu_n | input | 1 | Processor address strobe, active low |
| stb_ctl_n | input | 1 | Cache controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip select, active low |
| ilv_order | input | 1 | 1: interleaved beat order, 0: linear beat order |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-byte write enables, active low |
| wdata | input | LANES*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*8 | Tri-state read data |
| rdata_oe | output | 1 | High when `rdata` is driven |

## Verification
Single reads through each strobe establish the two-edge latency. Bursts are then run in both orders from odd start offsets, so the XOR sequence and the wrapping sum give different beat addresses. A burst with a stalled beat, a burst cut short by a fresh strobe, and a burst interrupted by a processor strobe with chip select inactive (carrying a write and an advance) separate holding, reloading and ignoring. Partial lane writes followed at once by a read, a deselect followed by an advance, and toggling the output enable between clocks each isolate one more path.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_DSEL = 2'd3
  } pbs_op_e;

  // offset of beat k from start offset s
  function automatic logic [BEAT_W-1:0] beat_off(input logic [BEAT_W-1:0] s,
                                                 input logic [BEAT_W-1:0] k,
                                                 input logic ilv);
    logic [BEAT_W-1:0] r;
    if (ilv) r = s ^ k;
    else     r = s + k;
    return r;
  endfunction
endpackage

// File: rtl/pbs_rst_sync.sv
module pbs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pbs_burst_ctl.sv
module pbs_burst_ctl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb_cpu_n,
  input  logic                    stb_ctl_n,
  input  logic                    adv_n,
  input  logic                    cs_n,
  input  logic                    ilv_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output pbs_op_e                 s1_op,
  output logic [ADDR_W-1:0]       s1_addr,
  output logic [LANES-1:0]        s1_we,
  output logic [LANES*LANE_W-1:0] s1_wd
);
  localparam int DW = LANES * LANE_W;

  logic              act_q, act_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  pbs_op_e           op_q, op_d;
  logic [ADDR_W-1:0] a_q, a_d;
  logic [LANES-1:0]  we_q, we_d;
  logic [DW-1:0]     wd_q, wd_d;
  logic              cpu_req, ctl_req, blocked, take, step;
  logic [BEAT_W-1:0] cnt_inc;

  always_comb begin
    cpu_req = !stb_cpu_n;
    ctl_req = !stb_ctl_n;
    blocked = cpu_req && cs_n;
    take    = !blocked && (cpu_req || ctl_req);
    step    = !blocked && !take && act_q && !adv_n;
    cnt_inc = cnt_q + 1'b1;

    act_d  = act_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    op_d   = OP_HOLD;
    a_d    = a_q;
    we_d   = we_q;
    wd_d   = wd_q;

    if (take) begin
      if (cs_n) begin
        act_d = 1'b0;
        op_d  = OP_DSEL;
      end else begin
        act_d  = 1'b1;
        cnt_d  = '0;
        base_d = addr;
        a_d    = addr;
        we_d   = ~lane_we_n;
        wd_d   = wdata;
        op_d   = (|(~lane_we_n)) ? OP_WR : OP_RD;
      end
    end else if (step) begin
      cnt_d = cnt_inc;
      a_d   = {base_q[ADDR_W-1:BEAT_W],
               beat_off(base_q[BEAT_W-1:0], cnt_inc, ilv_order)};
      we_d  = ~lane_we_n;
      wd_d  = wdata;
      op_d  = (|(~lane_we_n)) ? OP_WR : OP_RD;
    end
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      op_q  <= OP_HOLD;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      op_q  <= op_d;
    end
  end

  // datapath, loaded only with an access
  always_ff @(posedge clk) begin
    if (take && !cs_n) base_q <= base_d;
    if (op_d == OP_RD || op_d == OP_WR) begin
      a_q  <= a_d;
      we_q <= we_d;
      wd_q <= wd_d;
    end
  end

  assign s1_op   = op_q;
  assign s1_addr = a_q;
  assign s1_we   = we_q;
  assign s1_wd   = wd_q;
endmodule

// File: rtl/pbs_lane.sv
module pbs_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd_q <= mem[addr];
  end

  assign rd = rd_q;
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb_cpu_n,
  input  logic                    stb_ctl_n,
  input  logic                    adv_n,
  input  logic                    cs_n,
  input  logic                    ilv_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW = LANES * LANE_W;

  logic              rst_sn;
  pbs_op_e           s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_we;
  logic [DW-1:0]     s1_wd;
  logic [DW-1:0]     rd_word;
  logic [LANES-1:0]  lane_we;
  logic              lane_re;
  logic              drv_q, drv_d;

  pbs_rst_sync i_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  pbs_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .stb_cpu_n (stb_cpu_n),
    .stb_ctl_n (stb_ctl_n),
    .adv_n     (adv_n),
    .cs_n      (cs_n),
    .ilv_order (ilv_order),
    .addr      (addr),
    .lane_we_n (lane_we_n),
    .wdata     (wdata),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s1_we     (s1_we),
    .s1_wd     (s1_wd)
  );

  always_comb begin
    lane_re = (s1_op == OP_RD);
    lane_we = (s1_op == OP_WR) ? s1_we : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbs_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_lane (
      .clk  (clk),
      .we   (lane_we[g]),
      .re   (lane_re),
      .addr (s1_addr),
      .wd   (s1_wd[g*LANE_W +: LANE_W]),
      .rd   (rd_word[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    case (s1_op)
      OP_RD:          drv_d = 1'b1;
      OP_WR, OP_DSEL: drv_d = 1'b0;
      default:        drv_d = drv_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) drv_q <= 1'b0;
    else         drv_q <= drv_d;
  end

  assign rdata_oe = drv_q & ~oe_n;
  assign rdata    = rdata_oe ? rd_word : {DW{1'bz}};
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stb_cpu_n,
  input logic                    stb_ctl_n,
  input logic                    adv_n,
  input logic                    cs_n,
  input logic [LANES-1:0]        lane_we_n,
  input logic                    oe_n,
  input logic                    rdata_oe,
  input logic                    drv,
  input logic [LANES*LANE_W-1:0] rd_word
);
  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((!stb_ctl_n || !stb_cpu_n) && !cs_n && (&lane_we_n)) |=> ##1 drv);

  a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((!stb_ctl_n || !stb_cpu_n) && !cs_n && !(&lane_we_n)) |=> ##1 !drv);

  a_r8_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_ctl_n && stb_cpu_n && cs_n) |=> ##1 !drv);

  a_r7_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_cpu_n && cs_n) |=> ##1 ($stable(drv) && $stable(rd_word)));

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_cpu_n && stb_ctl_n && adv_n) |=> ##1 ($stable(drv) && $stable(rd_word)));

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);
endmodule

bind pipe_burst_sram pbs_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .stb_cpu_n (stb_cpu_n),
  .stb_ctl_n (stb_ctl_n),
  .adv_n     (adv_n),
  .cs_n      (cs_n),
  .lane_we_n (lane_we_n),
  .oe_n      (oe_n),
  .rdata_oe  (rdata_oe),
  .drv       (drv_q),
  .rd_word   (rd_word)
);

// File: tb/test_pipe_burst_sram.sv
module test_pipe_burst_sram;
  localparam int AW = 10;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, stb_cpu_n, stb_ctl_n, adv_n, cs_n, ilv_order, oe_n;
  logic [AW-1:0] addr;
  logic [7:0]    lane_we_n;
  logic [DW-1:0] wdata;
  wire  [DW-1:0] rdata;
  wire           rdata_oe;

  pipe_burst_sram #(.ADDR_W(AW)) i_pipe_burst_sram (
    .clk(clk), .rst_n(rst_n), .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
    .adv_n(adv_n), .cs_n(cs_n), .ilv_order(ilv_order), .addr(addr),
    .lane_we_n(lane_we_n), .wdata(wdata), .oe_n(oe_n), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    int          due;
    bit          on;
    logic [63:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [63:0] ref_mem [int];

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pop expected items when due
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      if (e.due < cyc) check({e.tag, " missed"}, 64'(cyc), 64'(e.due));
      else begin
        check({e.tag, " oe"}, 64'(rdata_oe), 64'(e.on));
        if (e.on) check({e.tag, " data"}, rdata, e.data);
      end
    end
  end

  task automatic push(bit on, logic [63:0] d, string tag);
    exp_t e;
    e.due = cyc + 2; e.on = on; e.data = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(bit cpu, bit ctl, bit adv, bit cs, logic [7:0] we,
                      int a, logic [63:0] wd);
    stb_cpu_n = cpu; stb_ctl_n = ctl; adv_n = adv; cs_n = cs;
    lane_we_n = we; addr = AW'(a); wdata = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1, 1, 1, 0, 8'hFF, 0, '0);
  endtask

  task automatic wr(int a, logic [7:0] we, logic [63:0] wd, string tag);
    logic [63:0] m;
    m = ref_mem.exists(a) ? ref_mem[a] : '0;
    for (int i = 0; i < 8; i++) if (!we[i]) m[i*8 +: 8] = wd[i*8 +: 8];
    ref_mem[a] = m;
    push(1'b0, '0, tag);
    step(1, 0, 1, 0, we, a, wd);
  endtask

  task automatic rd(bit use_cpu, int a, string tag);
    push(1'b1, ref_mem[a], tag);
    step(use_cpu ? 1'b0 : 1'b1, use_cpu ? 1'b1 : 1'b0, 1, 0, 8'hFF, a, '0);
  endtask

  task automatic adv(int a_exp, string tag);
    push(1'b1, ref_mem[a_exp], tag);
    step(1, 1, 0, 0, 8'hFF, 10'h3FF, '0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; ilv_order = 1'b1; oe_n = 1'b0;
    stb_cpu_n = 1; stb_ctl_n = 1; adv_n = 1; cs_n = 0;
    lane_we_n = 8'hFF; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset bus off", 64'(rdata_oe), 64'd0);

    for (int i = 0; i < 8; i++)
      wr('h40 + i, 8'h00, 64'h0102030405060708 + 64'(i) * 64'h1010101010101010,
         "R12 write bus off");
    idle();

    rd(1, 'h42, "R1 R2 cpu strobe read");
    idle();
    rd(0, 'h46, "R1 R2 ctl strobe read");
    idle();

    // interleaved from offset 1: 1,0,3,2
    rd(0, 'h45, "R4 il beat0");
    adv('h44, "R4 il beat1");
    adv('h47, "R4 il beat2");
    adv('h46, "R4 il beat3");
    idle();

    // linear from offset 3: 3,0,1,2
    ilv_order = 1'b0;
    rd(1, 'h47, "R4 lin beat0");
    adv('h44, "R4 lin beat1");
    adv('h45, "R4 lin beat2");
    adv('h46, "R4 lin beat3");
    idle();
    ilv_order = 1'b1;

    // stall
    rd(0, 'h40, "R3 stall beat0");
    push(1'b1, ref_mem['h40], "R3 stall hold");
    step(1, 1, 1, 0, 8'hFF, 'h43, '0);
    adv('h41, "R3 after stall");
    idle();

    // blocked processor strobe with write and advance
    rd(0, 'h42, "R7 burst start");
    push(1'b1, ref_mem['h42], "R7 blocked hold");
    step(0, 1, 0, 1, 8'h00, 'h47, 64'hFFFF_FFFF_FFFF_FFFF);
    adv('h43, "R7 counter kept");
    rd(0, 'h47, "R7 no write");
    idle();

    // abort
    rd(0, 'h44, "R10 first burst");
    adv('h45, "R10 first beat1");
    rd(0, 'h46, "R10 reload");
    adv('h47, "R10 new beat1");
    idle();

    // partial writes, read right after
    wr('h43, 8'hF0, 64'hDEAD_BEEF_CAFE_F00D, "R12 partial write");
    rd(0, 'h43, "R6 merged read");
    wr('h41, 8'h5A, 64'h1122_3344_5566_7788, "R12 partial write");
    rd(1, 'h41, "R5 lane mask");
    idle();

    // deselect
    rd(1, 'h40, "R8 before deselect");
    push(1'b0, '0, "R8 deselect off");
    step(1, 0, 1, 1, 8'hFF, 0, '0);
    push(1'b0, '0, "R8 advance after deselect");
    step(1, 1, 0, 0, 8'hFF, 0, '0);
    idle();

    // output enable
    rd(0, 'h41, "R9 read");
    idle(); idle();
    #2;
    check("R9 driven", 64'(rdata_oe), 64'd1);
    oe_n = 1'b1; #1;
    check("R9 oe high off", 64'(rdata_oe), 64'd0);
    oe_n = 1'b0; #1;
    check("R9 oe low on", 64'(rdata_oe), 64'd1);
    check("R9 data back", rdata, ref_mem['h41]);

    repeat (4) idle();
    check("R2 queue drained", 64'(q.size()), 64'd0);
    summary();
  end
endmodule